// File: doc/BRIEF.md
# Paged Write Sequencer

This block takes a write request (a byte offset into the flash and a byte count) plus a stream of payload bytes, and turns it into the command frames that a serial paged flash with an on-chip SRAM buffer expects. It cuts the request at page boundaries. When a chunk does not cover a whole page, it first has the device copy the current page contents into its buffer. This way the bytes that are not rewritten keep their old values. It then sends a program-through-buffer frame that carries the chunk's payload. It polls the device status until the device reports ready. Optionally it asks the device to compare the buffer with the array, and it stops with an error if the device reports a difference.

The payload arrives on a valid/ready byte stream. `s_ready` is asserted only while the data portion of a program frame is being sent, and it follows the SPI port's `spi_ready` there. Each payload byte therefore moves straight from `s_data` to `spi_tx` in the cycle it is accepted. In every other phase the stream is stalled, and a waiting byte stays held by its source. Commands go out through a byte-level transaction port. A byte moves on a clock edge where `spi_valid` and `spi_ready` are both high. The byte the device returns for it is presented on `spi_rx` in that same cycle. `spi_last` marks the final byte of a chip-select frame.

Page geometry is set by parameters. `PAGE_SIZE` is the number of bytes in a page, and it need not be a power of two. `PAGE_SHIFT` is the bit position of the page index within the 24-bit device address.

Top module: `paged_write_sequencer`

## Requirements
- R1: Chunking. The first chunk runs from `start_off % PAGE_SIZE` up to the end of that page, or up to the end of the request if that comes first. Each later chunk is a whole page, except the final one, which carries the remainder. The page index starts at `start_off / PAGE_SIZE` and goes up by one per chunk. The in-page offset is zero for every chunk after the first.
- R2: A chunk shorter than `PAGE_SIZE` is preceded by a 4-byte buffer-load frame `{0x53, PA[23:16], PA[15:8], 0x00}`, where PA = page index << `PAGE_SHIFT`. That frame is followed by status polling. A full-page chunk gets no load frame.
- R3: Each chunk is programmed with one frame: `0x82`, then address bytes A[23:16], A[15:8], A[7:0], then the chunk's payload bytes in stream order. A = PA + in-page offset. `spi_last` is high only on the last payload byte.
- R4: After every load, program and compare frame, the block sends status frames `{0xD7, 0x00}`. The status is the `spi_rx` byte returned with the `0x00`. The block repeats the status frame until status bit 7 (ready) is 1, and only then continues. While `spi_valid` is high and `spi_ready` is low, `spi_tx` and `spi_last` hold their values.
- R5: When `verify_en` was high at start, each program poll sequence is followed by a compare frame `{0x60, PA[23:16], PA[15:8], 0x00}` and its own polling. When `verify_en` was low, no compare frame is sent.
- R6: If the ready status after a compare has bit 6 set, the operation ends at once with `err_code` = 1. No further frames are sent and no further stream bytes are accepted.
- R7: If `POLL_LIMIT` status frames in a row return bit 7 = 0, the operation ends with `err_code` = 2. No further frames follow.
- R8: `s_ready` is high only during the payload part of a program frame. A payload byte is consumed exactly when it is sent.
- R9: A request of length 0 sends no frame and accepts no byte. It ends with a one-cycle `done` pulse and `err_code` = 0. `done` is high for exactly one cycle at the end of every operation, and `busy` is low in the following cycle.
- R10: `start` is ignored while `busy` is high. The frames of the running operation are unchanged by it.
- R11: After reset, `busy`, `done`, `s_ready`, `spi_valid` and `spi_last` are 0, and `err_code` is 0. `err_code` is set to 0 when a start is accepted, and it holds its final value after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (sampled only while idle) |
| start_off | input | OFF_W | Byte offset of the first byte in flash |
| req_len | input | LEN_W | Number of bytes to write |
| verify_en | input | 1 | Compare each page after it is programmed |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err_code | output | 2 | 0 none, 1 compare mismatch, 2 poll timeout |
| s_valid | input | 1 | Payload byte available |
| s_data | input | 8 | Payload byte |
| s_ready | output | 1 | Payload byte accepted |
| spi_valid | output | 1 | Byte to send is present |
| spi_ready | input | 1 | Transaction port takes the byte this cycle |
| spi_tx | output | 8 | Byte sent to the device |
| spi_last | output | 1 | Final byte of the current chip-select frame |
| spi_rx | input | 8 | Byte returned by the device for the byte taken this cycle |

## Verification
The hardest situation to reach is a compare mismatch that arrives only after several status polls. It has to land mid-request, after earlier chunks have already consumed stream bytes, so that the early stop can be seen both in the frame log and in the count of accepted stream bytes. The bench's device model returns "busy" for a chosen number of polls and raises the mismatch bit on a chosen compare. Random requests that cross several pages are combined with random stalls on both the stream and the transaction port. This produces mismatches on the first, middle and last chunk, as well as a directed poll timeout and a start pulse issued during a running operation.

// File: rtl/pws_pkg.sv
package pws_pkg;
  localparam logic [7:0] OP_LOAD_BUF   = 8'h53;
  localparam logic [7:0] OP_PROG_BUF   = 8'h82;
  localparam logic [7:0] OP_CMP_BUF    = 8'h60;
  localparam logic [7:0] OP_STATUS     = 8'hD7;
  localparam int         STAT_RDY_BIT  = 7;
  localparam int         STAT_DIFF_BIT = 6;
  localparam int         DEV_ADDR_W    = 24;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_MISMATCH = 2'd1,
    ERR_TIMEOUT  = 2'd2
  } err_e;

  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_PROG = 2'd1,
    PH_CMP  = 2'd2
  } phase_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PLAN    = 3'd1,
    ST_HDR     = 3'd2,
    ST_DATA    = 3'd3,
    ST_POLL_OP = 3'd4,
    ST_POLL_RD = 3'd5,
    ST_NEXT    = 3'd6,
    ST_DONE    = 3'd7
  } state_e;
endpackage

// File: rtl/pws_chunker.sv
module pws_chunker #(
  parameter int PAGE_SIZE = 264,
  parameter int OFF_W     = 24,
  parameter int LEN_W     = 16,
  localparam int PG_W     = $clog2(PAGE_SIZE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFF_W-1:0] load_off,
  input  logic [LEN_W-1:0] load_len,
  input  logic             advance,
  output logic [OFF_W-1:0] page_idx,
  output logic [PG_W-1:0]  in_off,
  output logic [PG_W-1:0]  chunk_len,
  output logic             rem_zero
);
  logic [OFF_W-1:0] page_q;
  logic [PG_W-1:0]  off_q;
  logic [LEN_W-1:0] rem_q;
  logic [LEN_W:0]   room;

  always_comb begin
    room = (LEN_W+1)'(PAGE_SIZE) - (LEN_W+1)'(off_q);
    if ({1'b0, rem_q} < room) chunk_len = PG_W'(rem_q);
    else                      chunk_len = PG_W'(room);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      off_q  <= '0;
      rem_q  <= '0;
    end else if (load) begin
      page_q <= OFF_W'(load_off / PAGE_SIZE);
      off_q  <= PG_W'(load_off % PAGE_SIZE);
      rem_q  <= load_len;
    end else if (advance) begin
      page_q <= page_q + OFF_W'(1);
      off_q  <= '0;
      rem_q  <= rem_q - LEN_W'(chunk_len);
    end
  end

  assign page_idx = page_q;
  assign in_off   = off_q;
  assign rem_zero = (rem_q == '0);

  // R1: a pending chunk is never empty and never crosses its page end
  p_chunk_fits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rem_zero |-> (chunk_len != '0) && ((LEN_W+1)'(off_q) + (LEN_W+1)'(chunk_len) <= (LEN_W+1)'(PAGE_SIZE)));

  // R1: after a chunk the next one starts at in-page offset zero
  p_next_at_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (in_off == '0));
endmodule

// File: rtl/pws_poll_guard.sv
module pws_poll_guard #(
  parameter int POLL_LIMIT = 4096,
  localparam int CNT_W     = $clog2(POLL_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic miss,
  output logic last_try
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (miss) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign last_try = (cnt_q == CNT_W'(POLL_LIMIT - 1));

  // R7: the miss count never passes the limit
  p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(POLL_LIMIT));
endmodule

// File: rtl/paged_write_sequencer.sv
module paged_write_sequencer #(
  parameter int PAGE_SIZE  = 264,
  parameter int PAGE_SHIFT = 9,
  parameter int POLL_LIMIT = 4096,
  parameter int OFF_W      = 24,
  parameter int LEN_W      = 16,
  localparam int PG_W      = $clog2(PAGE_SIZE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OFF_W-1:0] start_off,
  input  logic [LEN_W-1:0] req_len,
  input  logic             verify_en,
  output logic             busy,
  output logic             done,
  output logic [1:0]       err_code,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  output logic             s_ready,
  output logic             spi_valid,
  input  logic             spi_ready,
  output logic [7:0]       spi_tx,
  output logic             spi_last,
  input  logic [7:0]       spi_rx
);
  import pws_pkg::*;

  state_e st_q, st_d;
  phase_e ph_q, ph_d;
  err_e   err_q, err_d;
  logic [1:0]      idx_q, idx_d;
  logic [PG_W-1:0] dcnt_q, dcnt_d;
  logic            ver_q;

  logic [OFF_W-1:0] page_idx;
  logic [PG_W-1:0]  in_off, chunk_len;
  logic             rem_zero, load, advance;
  logic             last_try, poll_clr, poll_miss;
  logic             hs;
  logic [DEV_ADDR_W-1:0] pg_addr, byte_addr, sel_addr;
  logic [7:0]       hdr_b;
  logic             chunk_end;

  pws_chunker #(.PAGE_SIZE(PAGE_SIZE), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_chunk (
    .clk(clk), .rst_n(rst_n), .load(load), .load_off(start_off), .load_len(req_len),
    .advance(advance), .page_idx(page_idx), .in_off(in_off), .chunk_len(chunk_len),
    .rem_zero(rem_zero)
  );

  pws_poll_guard #(.POLL_LIMIT(POLL_LIMIT)) u_guard (
    .clk(clk), .rst_n(rst_n), .clr(poll_clr), .miss(poll_miss), .last_try(last_try)
  );

  assign hs        = spi_valid && spi_ready;
  assign load      = (st_q == ST_IDLE) && start;
  assign advance   = (st_q == ST_NEXT);
  assign poll_clr  = (st_q == ST_HDR) || (st_q == ST_DATA);
  assign poll_miss = (st_q == ST_POLL_RD) && hs && !spi_rx[STAT_RDY_BIT] && !last_try;
  assign chunk_end = (dcnt_q == chunk_len - PG_W'(1));

  // device addressing: page index in the upper bits, byte offset below
  assign pg_addr   = DEV_ADDR_W'(page_idx) << PAGE_SHIFT;
  assign byte_addr = pg_addr + DEV_ADDR_W'(in_off);
  assign sel_addr  = (ph_q == PH_PROG) ? byte_addr : {pg_addr[DEV_ADDR_W-1:8], 8'h00};

  always_comb begin
    case (idx_q)
      2'd0: begin
        case (ph_q)
          PH_LOAD: hdr_b = OP_LOAD_BUF;
          PH_PROG: hdr_b = OP_PROG_BUF;
          default: hdr_b = OP_CMP_BUF;
        endcase
      end
      2'd1:    hdr_b = sel_addr[23:16];
      2'd2:    hdr_b = sel_addr[15:8];
      default: hdr_b = sel_addr[7:0];
    endcase
  end

  // transaction port and stream handshake
  always_comb begin
    spi_valid = 1'b0;
    spi_tx    = 8'h00;
    spi_last  = 1'b0;
    s_ready   = 1'b0;
    case (st_q)
      ST_HDR: begin
        spi_valid = 1'b1;
        spi_tx    = hdr_b;
        spi_last  = (idx_q == 2'd3) && (ph_q != PH_PROG);
      end
      ST_DATA: begin
        spi_valid = s_valid;
        spi_tx    = s_data;
        spi_last  = chunk_end;
        s_ready   = spi_ready;
      end
      ST_POLL_OP: begin
        spi_valid = 1'b1;
        spi_tx    = OP_STATUS;
      end
      ST_POLL_RD: begin
        spi_valid = 1'b1;
        spi_last  = 1'b1;
      end
      default: ;
    endcase
  end

  // sequencing
  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    idx_d  = idx_q;
    dcnt_d = dcnt_q;
    err_d  = err_q;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d  = ST_PLAN;
        err_d = ERR_NONE;
      end
      ST_PLAN: begin
        if (rem_zero) st_d = ST_DONE;
        else begin
          ph_d  = (chunk_len != PG_W'(PAGE_SIZE)) ? PH_LOAD : PH_PROG;
          idx_d = 2'd0;
          st_d  = ST_HDR;
        end
      end
      ST_HDR: if (hs) begin
        if (idx_q == 2'd3) begin
          dcnt_d = '0;
          st_d   = (ph_q == PH_PROG) ? ST_DATA : ST_POLL_OP;
        end else begin
          idx_d = idx_q + 2'd1;
        end
      end
      ST_DATA: if (hs) begin
        if (chunk_end) st_d = ST_POLL_OP;
        else           dcnt_d = dcnt_q + PG_W'(1);
      end
      ST_POLL_OP: if (hs) st_d = ST_POLL_RD;
      ST_POLL_RD: if (hs) begin
        if (spi_rx[STAT_RDY_BIT]) begin
          case (ph_q)
            PH_LOAD: begin
              ph_d  = PH_PROG;
              idx_d = 2'd0;
              st_d  = ST_HDR;
            end
            PH_PROG: begin
              if (ver_q) begin
                ph_d  = PH_CMP;
                idx_d = 2'd0;
                st_d  = ST_HDR;
              end else begin
                st_d = ST_NEXT;
              end
            end
            default: begin
              if (spi_rx[STAT_DIFF_BIT]) begin
                err_d = ERR_MISMATCH;
                st_d  = ST_DONE;
              end else begin
                st_d = ST_NEXT;
              end
            end
          endcase
        end else if (last_try) begin
          err_d = ERR_TIMEOUT;
          st_d  = ST_DONE;
        end else begin
          st_d = ST_POLL_OP;
        end
      end
      ST_NEXT: st_d = ST_PLAN;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_PROG;
      err_q  <= ERR_NONE;
      idx_q  <= 2'd0;
      dcnt_q <= '0;
      ver_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      err_q  <= err_d;
      idx_q  <= idx_d;
      dcnt_q <= dcnt_d;
      if (load) ver_q <= verify_en;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = (st_q == ST_DONE);
  assign err_code = err_q;

  // R8: an accepted stream byte is the byte presented to the device
  p_stream_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && s_valid) |-> (spi_valid && spi_ready && spi_tx == s_data));

  // R4: a stalled command or status byte is held steady
  p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_valid && !spi_ready && !s_ready && st_q != ST_DATA) |=> (spi_valid && $stable(spi_tx) && $stable(spi_last)));

  // R9: done lasts one cycle and is followed by idle
  p_done_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R11: an accepted start clears the error code
  p_err_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && err_code == 2'd0));

  // R6: once an error is recorded the ports stay quiet
  p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 2'd0) |-> (!spi_valid && !s_ready));
endmodule

// File: tb/sim_paged_write_sequencer.sv
`timescale 1ns/1ps
module sim_paged_write_sequencer;
  localparam int PS = 12;
  localparam int SH = 4;
  localparam int PL = 6;
  localparam int OW = 24;
  localparam int LW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          start = 1'b0;
  logic [OW-1:0] start_off = '0;
  logic [LW-1:0] req_len = '0;
  logic          verify_en = 1'b0;
  logic          busy, done;
  logic [1:0]    err_code;
  logic          s_valid = 1'b0;
  logic [7:0]    s_data = 8'h00;
  logic          s_ready;
  logic          spi_valid;
  logic          spi_ready = 1'b0;
  logic [7:0]    spi_tx;
  logic          spi_last;
  logic [7:0]    spi_rx = 8'h00;

  paged_write_sequencer #(.PAGE_SIZE(PS), .PAGE_SHIFT(SH), .POLL_LIMIT(PL),
                          .OFF_W(OW), .LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_off(start_off), .req_len(req_len),
    .verify_en(verify_en), .busy(busy), .done(done), .err_code(err_code),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .spi_valid(spi_valid), .spi_ready(spi_ready), .spi_tx(spi_tx),
    .spi_last(spi_last), .spi_rx(spi_rx)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0] stream[$];
  logic [7:0] exp_b[$];
  bit         exp_l[$];
  logic [7:0] got_b[$];
  bit         got_l[$];
  int         s_ptr = 0;
  int         m_idx = 0;
  logic [7:0] m_op = 8'h00;
  logic [7:0] m_lastop = 8'h00;
  int         m_polls = 0;
  int         m_cmp = 0;
  int         cfg_busy = 0;
  int         cfg_mis = -1;
  int         viol = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // watchdog: a hung run is one failed check, then the summary
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // device model and stream source: drive after the falling edge, observe 1 ns later
  always @(negedge clk) begin
    spi_ready = ($urandom_range(3) != 0);
    s_valid   = (s_ptr < stream.size()) && ($urandom_range(2) != 0);
    s_data    = (s_ptr < stream.size()) ? stream[s_ptr] : 8'h00;
    if (m_idx == 1 && m_op == 8'hD7)
      spi_rx = {(m_polls >= cfg_busy), (m_lastop == 8'h60 && (m_cmp - 1) == cfg_mis), 6'h0C};
    else
      spi_rx = 8'h00;
    #1;
    if (s_ready && !(m_op == 8'h82 && m_idx >= 4)) viol++;
    if (spi_valid && spi_ready) begin
      got_b.push_back(spi_tx);
      got_l.push_back(spi_last);
      if (m_idx == 0) m_op = spi_tx;
      if (s_ready && s_valid) s_ptr++;
      if (spi_last) begin
        if (m_op == 8'hD7) m_polls++;
        else begin
          m_polls  = 0;
          m_lastop = m_op;
          if (m_op == 8'h60) m_cmp++;
        end
        m_idx = 0;
      end else begin
        m_idx++;
      end
    end
  end

  function automatic void push_frame4(input logic [7:0] op, input int a, input bit full);
    exp_b.push_back(op);          exp_l.push_back(1'b0);
    exp_b.push_back(8'(a >> 16)); exp_l.push_back(1'b0);
    exp_b.push_back(8'(a >> 8));  exp_l.push_back(1'b0);
    exp_b.push_back(full ? 8'(a) : 8'h00); exp_l.push_back(!full ? 1'b1 : 1'b0);
  endfunction

  function automatic bit add_polls(input int busy_n);
    int n = (busy_n >= PL) ? PL : busy_n + 1;
    for (int i = 0; i < n; i++) begin
      exp_b.push_back(8'hD7); exp_l.push_back(1'b0);
      exp_b.push_back(8'h00); exp_l.push_back(1'b1);
    end
    return busy_n < PL;
  endfunction

  // expected frame log from R1..R7
  task automatic build_exp(input int off, input int len, input bit ver, input int mis,
                           input int busy_n, output int e_err, output int e_cons);
    int page, io, rem, cmp, sp, cl, pa;
    page = off / PS; io = off % PS; rem = len; cmp = 0; sp = 0; e_err = 0;
    exp_b.delete(); exp_l.delete();
    while (rem > 0) begin
      cl = (PS - io < rem) ? PS - io : rem;
      pa = page << SH;
      if (cl != PS) begin
        push_frame4(8'h53, pa, 1'b0);
        if (!add_polls(busy_n)) begin e_err = 2; break; end
      end
      push_frame4(8'h82, pa + io, 1'b1);
      for (int i = 0; i < cl; i++) begin
        exp_b.push_back(stream[sp + i]);
        exp_l.push_back(i == cl - 1);
      end
      sp += cl;
      if (!add_polls(busy_n)) begin e_err = 2; break; end
      if (ver) begin
        push_frame4(8'h60, pa, 1'b0);
        if (!add_polls(busy_n)) begin e_err = 2; break; end
        if (cmp == mis) begin e_err = 1; break; end
        cmp++;
      end
      rem -= cl; page++; io = 0;
    end
    e_cons = sp;
  endtask

  task automatic run_op(input int off, input int len, input bit ver, input int mis,
                        input int busy_n, input bit mid, input string tag);
    int e_err, e_cons, n, first_bad;
    @(negedge clk); #2;
    stream.delete();
    for (int i = 0; i < len; i++) stream.push_back(8'($urandom));
    got_b.delete(); got_l.delete();
    s_ptr = 0; m_idx = 0; m_op = 8'h00; m_lastop = 8'h00; m_polls = 0; m_cmp = 0; viol = 0;
    cfg_busy = busy_n; cfg_mis = mis;
    build_exp(off, len, ver, mis, busy_n, e_err, e_cons);
    start = 1'b1; start_off = OW'(off); req_len = LW'(len); verify_en = ver;
    @(negedge clk); #2; start = 1'b0;
    if (mid) begin
      repeat (8) @(negedge clk);
      #2; start = 1'b1; start_off = 0; req_len = 5; verify_en = !ver;
      @(negedge clk); #2; start = 1'b0;
    end
    n = 0;
    while (n < 20000) begin
      @(negedge clk); #1.5;
      if (done) break;
      n++;
    end
    check(done == 1'b1, "R9", {tag, " done seen"}, int'(done), 1);
    check(err_code == 2'(e_err), "R6 R7", {tag, " err_code"}, int'(err_code), e_err);
    first_bad = -1;
    for (int i = 0; i < exp_b.size() && i < got_b.size(); i++)
      if (first_bad < 0 && (got_b[i] != exp_b[i] || got_l[i] != exp_l[i])) first_bad = i;
    if (first_bad >= 0)
      check(1'b0, "R1 R2 R3 R4 R5", {tag, " frame byte"}, int'(got_b[first_bad]), int'(exp_b[first_bad]));
    else
      check(got_b.size() == exp_b.size(), "R1 R2 R3 R4 R5 R10", {tag, " frame log length"},
            got_b.size(), exp_b.size());
    check(s_ptr == e_cons, "R8 R6", {tag, " stream bytes consumed"}, s_ptr, e_cons);
    check(viol == 0, "R8", {tag, " s_ready outside payload"}, viol, 0);
    @(negedge clk); #1.5;
    check(!busy && !done, "R9", {tag, " idle after done"}, int'(busy) + int'(done), 0);
    check(err_code == 2'(e_err), "R11", {tag, " err_code held"}, int'(err_code), e_err);
    stream.delete();
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1.5;
    check(!busy && !done && !s_ready && !spi_valid && !spi_last && err_code == 2'd0,
          "R11", "reset state", int'(busy) + int'(spi_valid) + int'(err_code), 0);
    #1; rst_n = 1'b1;

    run_op(0,  12, 1'b0, -1, 0,   1'b0, "R3 full aligned page");
    run_op(5,  3,  1'b1, -1, 1,   1'b0, "R2 partial in-page");
    run_op(7,  30, 1'b1, -1, 2,   1'b0, "R1 multi-page");
    run_op(50, 0,  1'b1, -1, 0,   1'b0, "R9 zero length");
    run_op(3,  30, 1'b1, 1,  1,   1'b0, "R6 mismatch mid");
    run_op(24, 12, 1'b0, -1, 100, 1'b0, "R7 poll timeout");
    run_op(2,  20, 1'b0, -1, 3,   1'b1, "R10 start while busy");
    run_op(11, 2,  1'b1, 0,  0,   1'b0, "R6 mismatch first");
    run_op(36, 24, 1'b1, -1, PL - 1, 1'b0, "R4 last poll ready");

    for (int t = 0; t < 25; t++) begin
      int off, len, mis, bz;
      bit ver;
      off = $urandom_range(200);
      len = $urandom_range(40);
      ver = 1'($urandom_range(1));
      mis = ($urandom_range(1) != 0) ? -1 : int'($urandom_range(3));
      bz  = $urandom_range(3);
      run_op(off, len, ver, mis, bz, 1'b0, "R1 R5 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule